// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block is the device side of a three-wire serial EEPROM with 64 words of 16 bits. It watches chip select, serial clock and serial data in, which it brings into the system clock domain. It collects a command framed as a start bit, a two-bit opcode and a six-bit word address. It then reads, writes or erases one word, writes or erases the whole array, or sets or clears a write-enable latch. The array is a register file inside the block.

Modifying commands are committed by a self-timed programming cycle. The cycle is counted in system clocks and begins when chip select drops after the command. While chip select is high again after that, the serial output reports busy or ready. A host polls this pin to learn when the next command may be sent. The output pin is modelled as a data value plus an output-enable.

Top module: `mw_eeprom_engine`

## Requirements
- R1: After reset the output enable is low, every word reads 0xFFFF, and the write-enable latch is clear, so WRITE, ERASE, write-all and erase-all change nothing.
- R2: A command is a 1 start bit, then opcode bits (first bit is the MSB), then address A5 down to A0. Opcode 10 is READ. After the last address bit the output drives a 0, and then drives D15 down to D0, one bit per following serial clock rising edge. The output is enabled throughout.
- R3: Opcode 01 is WRITE. The data bits that follow are shifted in MSB first, and the last 16 received are written to the addressed word.
- R4: Opcode 11 is ERASE, which sets the addressed word to 0xFFFF.
- R5: Opcode 00 with A5A4 = 01 is write-all, which writes the last 16 received data bits into every word.
- R6: Opcode 00 with A5A4 = 10 is erase-all, which sets every word to 0xFFFF.
- R7: Opcode 00 with A5A4 = 11 sets the write-enable latch, and A5A4 = 00 clears it. A modifying command issued while the latch is clear changes nothing and starts no programming cycle.
- R8: Programming starts only when chip select falls after a complete modifying command. A command cut short by chip select falling before its last address bit changes nothing.
- R9: When chip select is raised after programming starts, the output is enabled. It reads 0 until PROG_CYCLES system clocks have elapsed and 1 afterwards.
- R10: The ready/busy indication stops being driven after a serial clock rising edge that sees both chip select and data in high.
- R11: Start bits that arrive while programming is in progress are ignored, so the whole command they begin has no effect.
- R12: Whenever synchronized chip select is low, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select from the host, asynchronous |
| sk_i | input | 1 | Serial clock from the host, asynchronous |
| di_i | input | 1 | Serial data in, sampled on serial clock rising edges |
| do_o | output | 1 | Serial data out, or the ready/busy level |
| do_oe_o | output | 1 | Output enable for do_o; low means the pin floats |

## Verification
The assertions take it for granted that the serial clock is slow compared with the system clock. Each of its levels must last longer than the synchronizer depth plus one cycle, data in must be steady around each serial clock rising edge, and chip select must change only while the serial clock is low. The stimulus meets all of these. It holds every serial clock level for four system clocks, changes data in and chip select only in the low phase, and waits several cycles after each chip-select edge before it samples.

// File: rtl/mw_pkg.sv
// Shared widths and encodings for the serial EEPROM command engine.
package mw_pkg;
    parameter int ADDR_W = 6;
    parameter int WORD_W = 16;

    // Receive/decode sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_RD,
        ST_DAT,
        ST_HOLD
    } mw_state_e;

    // Decoded command kind.
    typedef enum logic [2:0] {
        K_NONE,
        K_READ,
        K_WRITE,
        K_ERASE,
        K_WRALL,
        K_ERAL,
        K_MISC
    } mw_kind_e;
endpackage

// File: rtl/mw_in_sync.sv
// Brings chip select, serial clock and data in into the system clock domain.
// Emits a serial-clock rising pulse and a chip-select falling pulse.
// Assumes each input level lasts longer than STAGES+1 system clocks.
module mw_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_s,
    output logic sk_s,
    output logic di_s,
    output logic sk_rise,
    output logic cs_fall
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] pipe [STAGES];
    logic [NSIG-1:0] last_q;

    // First synchronizer stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= {cs_i, sk_i, di_i};
    end

    // Remaining synchronizer stages.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    // One-cycle delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= pipe[STAGES-1];
    end

    assign cs_s    = pipe[STAGES-1][2];
    assign sk_s    = pipe[STAGES-1][1];
    assign di_s    = pipe[STAGES-1][0];
    assign sk_rise = sk_s & ~last_q[1];
    assign cs_fall = ~cs_s & last_q[2];
endmodule

// File: rtl/mw_cmd_fsm.sv
// Shifts in start bit, opcode, address and data, and decodes the command.
// Shifts read data out and raises a programming request on chip-select fall.
// Assumes synchronized inputs; ignores start bits while busy is high.
module mw_cmd_fsm
    import mw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          cs_fall,
    input  logic          sk_rise,
    input  logic          di_s,
    input  logic          busy,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] addr_o,
    output mw_kind_e      kind_o,
    output logic [DW-1:0] data_o,
    output logic          req_o,
    output logic          wen_set_o,
    output logic          wen_clr_o,
    output logic          idle_o,
    output logic          rd_active_o,
    output logic          rd_bit_o
);
    localparam int CW = $clog2(AW) + 1;

    mw_state_e     state;
    logic [CW-1:0] cnt;
    logic [1:0]    op;
    logic [AW-1:0] adr;
    mw_kind_e      kind;
    logic [DW-1:0] dsr;
    logic [DW-1:0] rsr;
    logic          rfirst;
    logic          rbit;

    logic          last_adr;
    logic [AW-1:0] adr_n;
    logic          is_mod;

    // Decode helpers for the cycle that receives the last address bit.
    always_comb begin
        adr_n    = {adr[AW-2:0], di_s};
        last_adr = cs_s && sk_rise && (state == ST_ADR) && (cnt == CW'(AW-1));
        is_mod   = (kind == K_WRITE) || (kind == K_ERASE) ||
                   (kind == K_WRALL) || (kind == K_ERAL);
    end

    // Latch control pulses and programming request.
    always_comb begin
        wen_set_o = last_adr && (op == 2'b00) && (adr_n[AW-1 -: 2] == 2'b11);
        wen_clr_o = last_adr && (op == 2'b00) && (adr_n[AW-1 -: 2] == 2'b00);
        req_o     = cs_fall && is_mod && ((state == ST_DAT) || (state == ST_HOLD));
    end

    // Command sequencer: shifting, decode and read-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            op     <= '0;
            adr    <= '0;
            kind   <= K_NONE;
            dsr    <= '0;
            rsr    <= '0;
            rfirst <= 1'b0;
            rbit   <= 1'b0;
        end else if (!cs_s) begin
            state <= ST_IDLE;
            rbit  <= 1'b0;
        end else if (sk_rise) begin
            case (state)
                ST_IDLE: begin
                    if (di_s && !busy) begin
                        state <= ST_OPC;
                        cnt   <= '0;
                        kind  <= K_NONE;
                    end
                end
                ST_OPC: begin
                    op <= {op[0], di_s};
                    if (cnt == CW'(1)) begin
                        state <= ST_ADR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_ADR: begin
                    adr <= adr_n;
                    if (cnt == CW'(AW-1)) begin
                        case (op)
                            2'b10: begin
                                kind   <= K_READ;
                                state  <= ST_RD;
                                rfirst <= 1'b1;
                                rbit   <= 1'b0;
                            end
                            2'b01: begin
                                kind  <= K_WRITE;
                                state <= ST_DAT;
                                dsr   <= '0;
                            end
                            2'b11: begin
                                kind  <= K_ERASE;
                                state <= ST_HOLD;
                            end
                            default: begin
                                case (adr_n[AW-1 -: 2])
                                    2'b01: begin
                                        kind  <= K_WRALL;
                                        state <= ST_DAT;
                                        dsr   <= '0;
                                    end
                                    2'b10: begin
                                        kind  <= K_ERAL;
                                        state <= ST_HOLD;
                                    end
                                    default: begin
                                        kind  <= K_MISC;
                                        state <= ST_HOLD;
                                    end
                                endcase
                            end
                        endcase
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RD: begin
                    if (rfirst) begin
                        rbit   <= rd_word[DW-1];
                        rsr    <= {rd_word[DW-2:0], 1'b0};
                        rfirst <= 1'b0;
                    end else begin
                        rbit <= rsr[DW-1];
                        rsr  <= {rsr[DW-2:0], 1'b0};
                    end
                end
                ST_DAT: begin
                    dsr <= {dsr[DW-2:0], di_s};
                end
                default: ;
            endcase
        end
    end

    assign addr_o      = adr;
    assign kind_o      = kind;
    assign data_o      = dsr;
    assign idle_o      = (state == ST_IDLE);
    assign rd_active_o = (state == ST_RD);
    assign rd_bit_o    = rbit;

    AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == ST_IDLE) |=> (state == ST_IDLE)); // R11
    AST_READ_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (last_adr && op == 2'b10) |=> (rd_bit_o == 1'b0)); // R2
endmodule

// File: rtl/mw_prog_timer.sv
// Self-timed programming cycle: captures the operation at start, counts
// CYCLES system clocks, and commits to the array on the final count.
// Assumes start is never raised while busy.
module mw_prog_timer
    import mw_pkg::*;
#(
    parameter int CYCLES = 64,
    parameter int AW     = ADDR_W,
    parameter int DW     = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  mw_kind_e      kind,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          busy,
    output logic          we,
    output logic          all,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    localparam int CNTW = $clog2(CYCLES + 1);

    logic [CNTW-1:0] cnt;

    // Countdown and operation capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            all   <= 1'b0;
            waddr <= '0;
            wdata <= '0;
        end else if (start) begin
            cnt   <= CNTW'(CYCLES);
            all   <= (kind == K_WRALL) || (kind == K_ERAL);
            waddr <= addr;
            wdata <= ((kind == K_ERASE) || (kind == K_ERAL)) ? '1 : data;
        end else if (cnt != '0) begin
            cnt <= cnt - CNTW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign we   = (cnt == CNTW'(1));

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R11
endmodule

// File: rtl/mw_word_array.sv
// Register-file array of 2**AW words, erased (all ones) at reset.
// One write port with a broadcast mode, one combinational read port.
module mw_word_array
    import mw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Word storage with single-word or whole-array write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (we && (all || waddr == AW'(i)))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mw_eeprom_engine.sv
// Top of the serial EEPROM command engine. Holds the write-enable latch
// and the ready/busy status flag, and drives the serial output and its enable.
// Assumes the host serial clock is far slower than clk.
module mw_eeprom_engine
    import mw_pkg::*;
#(
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int AW = ADDR_W;
    localparam int DW = WORD_W;

    logic          cs_s, sk_s, di_s, sk_rise, cs_fall;
    logic [AW-1:0] cmd_addr;
    mw_kind_e      cmd_kind;
    logic [DW-1:0] cmd_data;
    logic          req, wen_set, wen_clr, idle, rd_active, rd_bit;
    logic          busy, arr_we, arr_all;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata, arr_rdata;
    logic          wen_q, stat_q, prog_start;

    mw_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
        .cs_s(cs_s), .sk_s(sk_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
        .sk_rise(sk_rise), .di_s(di_s), .busy(busy), .rd_word(arr_rdata),
        .addr_o(cmd_addr), .kind_o(cmd_kind), .data_o(cmd_data), .req_o(req),
        .wen_set_o(wen_set), .wen_clr_o(wen_clr), .idle_o(idle),
        .rd_active_o(rd_active), .rd_bit_o(rd_bit)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES), .AW(AW), .DW(DW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .kind(cmd_kind),
        .addr(cmd_addr), .data(cmd_data), .busy(busy), .we(arr_we),
        .all(arr_all), .waddr(arr_waddr), .wdata(arr_wdata)
    );

    mw_word_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .all(arr_all),
        .waddr(arr_waddr), .wdata(arr_wdata), .raddr(cmd_addr), .rdata(arr_rdata)
    );

    assign prog_start = req && wen_q && !busy;

    // Write-enable latch, clear at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       wen_q <= 1'b0;
        else if (wen_set) wen_q <= 1'b1;
        else if (wen_clr) wen_q <= 1'b0;
    end

    // Ready/busy reporting flag: set by a programming start, dropped by a start-type edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  stat_q <= 1'b0;
        else if (prog_start)                         stat_q <= 1'b1;
        else if (sk_rise && cs_s && di_s && idle)    stat_q <= 1'b0;
    end

    // Output pin: read data during READ, otherwise ready level.
    always_comb begin
        do_o    = rd_active ? rd_bit : ~busy;
        do_oe_o = cs_s && (rd_active || (idle && stat_q));
    end

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !do_oe_o); // R12
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy); // R8
    AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q)); // R7
    AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !busy); // R9
    AST_STATUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_rise && cs_s && di_s && idle && !prog_start) |=> !stat_q); // R10
endmodule

// File: tb/sim_mw_eeprom_engine.sv
// Bench for the serial EEPROM engine: behavioural array model, serial host tasks.
module sim_mw_eeprom_engine;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, doe;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem_m [64];
    bit wen_m = 1'b0;
    int cs_low_run = 0;

    always #10 clk = ~clk;

    mw_eeprom_engine #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(dout), .do_oe_o(doe)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Every clock: output enable must be low once chip select has been low a while (R12).
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs) cs_low_run++;
            else     cs_low_run = 0;
            if (cs_low_run >= 4) check("R12 oe with cs low", {15'd0, doe}, 16'd0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        di = b; tick(4); sk = 1'b1; tick(4); sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic cs_on;  cs = 1'b1; tick(4); endtask
    task automatic cs_off; di = 1'b0; cs = 1'b0; tick(6); endtask

    task automatic hdr(input logic [1:0] op, input logic [5:0] a);
        sbit(1'b1); send({30'd0, op}, 2); send({26'd0, a}, 6);
    endtask

    // READ a word and compare the leading zero and data against the model (R2).
    task automatic read_chk(input logic [5:0] a, input string req);
        logic [15:0] got;
        cs_on; hdr(2'b10, a);
        check("R2 dummy bit oe/do", {14'd0, doe, dout}, 16'd2);
        for (int i = 15; i >= 0; i--) begin
            sbit(1'b0);
            got[i] = dout;
        end
        check(req, got, mem_m[a]);
        cs_off;
        check("R12 oe after read", {15'd0, doe}, 16'd0);
    endtask

    // Poll status after a programming command (R9, R10), or expect no status (R7).
    task automatic poll(input bit started);
        cs_on;
        if (started) begin
            check("R9 busy reads 0", {14'd0, doe, dout}, 16'd2);
            tick(PROG + 40);
            check("R9 ready reads 1", {14'd0, doe, dout}, 16'd3);
            sbit(1'b1);
            check("R10 status cleared", {15'd0, doe}, 16'd0);
        end else begin
            check("R7 no status when disabled", {15'd0, doe}, 16'd0);
        end
        cs_off;
    endtask

    task automatic misc(input logic [1:0] sel);
        cs_on; hdr(2'b00, {sel, 4'b1010}); cs_off;
        if (sel == 2'b11) wen_m = 1'b1;
        if (sel == 2'b00) wen_m = 1'b0;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d, input int nbits);
        cs_on; hdr(2'b01, a); send(d, nbits); cs_off;
        if (wen_m) mem_m[a] = d[15:0];
        poll(wen_m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
        tick(5); rst_n = 1'b1; tick(3);
        check("R1 oe after reset", {15'd0, doe}, 16'd0);
        read_chk(6'd5, "R1 erased after reset");

        // Writes blocked before enable (R1, R7).
        do_write(6'd5, 32'h1234, 16);
        read_chk(6'd5, "R1 write blocked");

        misc(2'b11);
        do_write(6'd5, 32'hA5C3, 16);
        read_chk(6'd5, "R3 write word");
        do_write(6'd9, 32'h2_5A0F, 18);
        read_chk(6'd9, "R3 last 16 bits used");
        read_chk(6'd5, "R3 neighbour untouched");

        // ERASE (R4).
        cs_on; hdr(2'b11, 6'd5); cs_off; mem_m[5] = 16'hFFFF; poll(1'b1);
        read_chk(6'd5, "R4 erase word");

        // Write-all (R5).
        cs_on; hdr(2'b00, 6'b01_0000); send(32'h0F0F, 16); cs_off;
        for (int i = 0; i < 64; i++) mem_m[i] = 16'h0F0F;
        poll(1'b1);
        read_chk(6'd0, "R5 write-all word 0");
        read_chk(6'd63, "R5 write-all word 63");

        // Aborted command (R8).
        cs_on; hdr(2'b00, 6'd0); cs_off;
        cs_on; sbit(1'b1); send(32'b01, 2); send(32'b000, 3); cs_off;
        poll(1'b0);
        read_chk(6'd3, "R8 aborted write");

        // Command during busy is ignored (R11).
        misc(2'b11);
        cs_on; hdr(2'b01, 6'd7); send(32'h1111, 16); cs_off; mem_m[7] = 16'h1111;
        cs_on; hdr(2'b01, 6'd8); send(32'h2222, 16); cs_off;
        tick(PROG + 40);
        read_chk(6'd7, "R11 first write done");
        read_chk(6'd8, "R11 write during busy ignored");

        // Erase-all (R6).
        cs_on; hdr(2'b00, 6'b10_0000); cs_off;
        for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
        poll(1'b1);
        read_chk(6'd8, "R6 erase-all word 8");
        read_chk(6'd7, "R6 erase-all word 7");

        // Disable then write (R7).
        misc(2'b00);
        do_write(6'd2, 32'h0000, 16);
        read_chk(6'd2, "R7 write after disable");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule